// File: doc/BRIEF.md
# Learning MAC Address Table with Aging

This block is the layer-2 address memory for a three-port switch: two LAN ports (port 0 and port 1) and one CPU port (port 2). Each frame header presented on the request interface does two things. Its source MAC address is learned against the port it arrived on. Its destination MAC address is looked up, and the block returns a bitmap of the ports the frame should leave on. A destination that is not in the table is flooded to every port except the one the frame came in on.

The table holds 1024 entries. Each entry carries a MAC address, a learned-port bitmap, a VLAN member-set index, a proxy flag and a 3-bit age code. Entries can be dynamic or static. Dynamic entries are created by learning and are removed by a background aging sweep. Static entries are written through a separate port and never age. The slot for an address is either its low address bits or a folded XOR hash, selected by a mode input. A learn-disable input turns the switch into a hub: nothing is learned and every frame is flooded.

Top module: `mac_learn_table`

## Requirements
- R1: A response (`rsp_valid_o` high for one cycle) appears exactly two clock edges after the edge that samples `req_valid_i`. `rsp_valid_o` is low in every other cycle.
- R2: The source of each request is learned with a one-hot port map (bit 0 = LAN0, bit 1 = LAN1, bit 2 = CPU), the request's VLAN index, and the proxy flag set only when the ingress is port 2. A later lookup of that address returns hit=1 with that map, VLAN index and proxy flag.
- R3: A destination miss returns hit=0 and a map with every port bit set except the ingress port.
- R4: On a hit, the ingress port is removed from the returned map, so a destination learned on the ingress port yields map 000.
- R5: With `learn_en_i` low at request time, nothing is learned and the response is hit=0 with the flood map, whatever the table holds.
- R6: The slot index is MAC[9:0] when `hash_mode_i`=0. When `hash_mode_i`=1 it is MAC[9:0] ^ MAC[25:16] ^ MAC[41:32].
- R7: A learn that lands on a slot holding a dynamic entry replaces it, even if the address differs. A slot holding a static entry is never replaced by learning.
- R8: Static entries written with `st_wr_i` are returned by lookups with their programmed map and VLAN index. Learning the same address from any port does not change them, and aging never removes them.
- R9: A newly learned entry survives five aging steps and is gone after the sixth (age code 1 counts up to 6, then wraps to 0 = free).
- R10: Learning an address that is already present restarts its age at 1.
- R11: While `age_en_i` is low, `age_tick_i` pulses have no effect on any entry.
- R12: One aging step occurs for every `age_div_i` pulses of `age_tick_i`. A divider of 0 acts as 1.
- R13: After reset the table is empty, every lookup misses, and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Frame header request strobe |
| req_src_mac_i | input | 48 | Source MAC to learn |
| req_dst_mac_i | input | 48 | Destination MAC to look up |
| req_port_i | input | 2 | Ingress port (0, 1 LAN; 2 CPU) |
| req_vid_i | input | 3 | VLAN member-set index stored on learning |
| learn_en_i | input | 1 | Learning enable; low selects hub behaviour |
| hash_mode_i | input | 1 | 0 direct index, 1 folded XOR hash |
| st_wr_i | input | 1 | Write a static entry |
| st_mac_i | input | 48 | Static entry address |
| st_port_map_i | input | 3 | Static entry port map |
| st_vid_i | input | 3 | Static entry VLAN index |
| age_en_i | input | 1 | Aging enable |
| age_tick_i | input | 1 | Aging base tick pulse |
| age_div_i | input | 16 | Base ticks per aging step |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Destination found |
| rsp_port_map_o | output | 3 | Egress port bitmap |
| rsp_vid_o | output | 3 | VLAN index of the hit entry |
| rsp_proxy_o | output | 1 | Proxy flag of the hit entry |

## Verification
The assertions assume that `req_port_i` only takes the values 0, 1 and 2 while `req_valid_i` is high. They also assume that the inputs hold steady through the two-cycle window in which their effect is checked, with the past ingress port and learn-enable recovered through `$past`. The bench drives every input on the falling edge and uses only legal port numbers. It spaces aging ticks by more than a full 1024-slot sweep, so no step overlaps a sweep still in flight. Each scenario starts from a fresh reset and uses addresses chosen so that probe lookups never share a slot with the entry under test.

// File: rtl/mac_tbl_pkg.sv
package mac_tbl_pkg;
  localparam int MAC_W    = 48;
  localparam int NPORT    = 3;
  localparam int PORT_W   = 2;
  localparam int AGE_W    = 3;
  localparam int CPU_PORT = 2;

  typedef logic [MAC_W-1:0] mac_t;
  typedef logic [NPORT-1:0] pmap_t;
  typedef logic [AGE_W-1:0] age_t;

  localparam age_t AGE_FREE   = 3'd0;
  localparam age_t AGE_NEW    = 3'd1;
  localparam age_t AGE_LAST   = 3'd6;
  localparam age_t AGE_STATIC = 3'd7;

  function automatic pmap_t port_bit(input logic [PORT_W-1:0] p);
    port_bit = pmap_t'(1) << p;
  endfunction

  function automatic age_t age_next(input age_t a);
    if (a == AGE_FREE || a == AGE_STATIC) age_next = a;
    else if (a == AGE_LAST)               age_next = AGE_FREE;
    else                                  age_next = a + age_t'(1);
  endfunction
endpackage

// File: rtl/mac_tbl_index.sv
module mac_tbl_index
  import mac_tbl_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  mac_t             mac_i,
  input  logic             hash_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int HALVES = MAC_W / 16;

  logic [IDX_W-1:0] fold;

  always_comb begin
    fold = '0;
    for (int h = 0; h < HALVES; h++) fold = fold ^ mac_i[h*16 +: IDX_W];
  end

  assign idx_o = hash_i ? fold : mac_i[IDX_W-1:0];
endmodule

// File: rtl/mac_tbl_age_ctl.sv
module mac_tbl_age_ctl
  import mac_tbl_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             age_en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sweep_o,
  output logic [IDX_W-1:0] sweep_idx_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = '1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   cnt_inc, div_eff;
  logic             step;
  logic             busy_q, pend_q, wrap;
  logic [IDX_W-1:0] ptr_q;

  assign div_eff = (div_i == '0) ? (DIV_W+1)'(1) : {1'b0, div_i};
  assign cnt_inc = {1'b0, cnt_q} + (DIV_W+1)'(1);
  assign step    = age_en_i && tick_i && (cnt_inc >= div_eff);
  assign wrap    = busy_q && (ptr_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!age_en_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= step ? '0 : cnt_inc[DIV_W-1:0];
  end

  // one slot per cycle; a step arriving mid-sweep queues one more pass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (busy_q) ptr_q <= ptr_q + IDX_W'(1);
      if (!busy_q)   busy_q <= step;
      else if (wrap) busy_q <= pend_q | step;
      if (wrap)                pend_q <= 1'b0;
      else if (busy_q && step) pend_q <= 1'b1;
    end
  end

  assign sweep_o     = busy_q;
  assign sweep_idx_o = ptr_q;
endmodule

// File: rtl/mac_tbl_store.sv
module mac_tbl_store
  import mac_tbl_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int VID_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] src_idx_i,
  output age_t             src_age_o,
  input  logic [IDX_W-1:0] dst_idx_i,
  output age_t             dst_age_o,
  output mac_t             dst_mac_o,
  output pmap_t            dst_map_o,
  output logic [VID_W-1:0] dst_vid_o,
  output logic             dst_proxy_o,
  input  logic             lrn_we_i,
  input  logic [IDX_W-1:0] lrn_idx_i,
  input  mac_t             lrn_mac_i,
  input  pmap_t            lrn_map_i,
  input  logic [VID_W-1:0] lrn_vid_i,
  input  logic             lrn_proxy_i,
  input  logic             st_we_i,
  input  logic [IDX_W-1:0] st_idx_i,
  input  mac_t             st_mac_i,
  input  pmap_t            st_map_i,
  input  logic [VID_W-1:0] st_vid_i,
  input  logic             sweep_i,
  input  logic [IDX_W-1:0] sweep_idx_i
);
  localparam int DEPTH = 1 << IDX_W;

  mac_t             mac_q   [DEPTH];
  pmap_t            map_q   [DEPTH];
  logic [VID_W-1:0] vid_q   [DEPTH];
  logic             proxy_q [DEPTH];
  age_t             age_q   [DEPTH];

  // later writes win: static over learn over sweep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '{default: AGE_FREE};
    end else begin
      if (sweep_i)  age_q[sweep_idx_i] <= age_next(age_q[sweep_idx_i]);
      if (lrn_we_i) age_q[lrn_idx_i]   <= AGE_NEW;
      if (st_we_i)  age_q[st_idx_i]    <= AGE_STATIC;
    end
  end

  always_ff @(posedge clk_i) begin
    if (lrn_we_i) begin
      mac_q[lrn_idx_i]   <= lrn_mac_i;
      map_q[lrn_idx_i]   <= lrn_map_i;
      vid_q[lrn_idx_i]   <= lrn_vid_i;
      proxy_q[lrn_idx_i] <= lrn_proxy_i;
    end
    if (st_we_i) begin
      mac_q[st_idx_i]   <= st_mac_i;
      map_q[st_idx_i]   <= st_map_i;
      vid_q[st_idx_i]   <= st_vid_i;
      proxy_q[st_idx_i] <= 1'b0;
    end
  end

  assign src_age_o   = age_q[src_idx_i];
  assign dst_age_o   = age_q[dst_idx_i];
  assign dst_mac_o   = mac_q[dst_idx_i];
  assign dst_map_o   = map_q[dst_idx_i];
  assign dst_vid_o   = vid_q[dst_idx_i];
  assign dst_proxy_o = proxy_q[dst_idx_i];
endmodule

// File: rtl/mac_tbl_decide.sv
module mac_tbl_decide
  import mac_tbl_pkg::*;
#(
  parameter int VID_W = 3
) (
  input  logic              valid_i,
  input  logic              learn_en_i,
  input  logic [PORT_W-1:0] port_i,
  input  mac_t              dst_mac_i,
  input  age_t              src_age_i,
  input  age_t              dst_age_i,
  input  mac_t              dst_ent_mac_i,
  input  pmap_t             dst_map_i,
  input  logic [VID_W-1:0]  dst_vid_i,
  input  logic              dst_proxy_i,
  output logic              lrn_we_o,
  output pmap_t             lrn_map_o,
  output logic              lrn_proxy_o,
  output logic              hit_o,
  output pmap_t             map_o,
  output logic [VID_W-1:0]  vid_o,
  output logic              proxy_o
);
  pmap_t ingress, flood;

  assign ingress = port_bit(port_i);
  assign flood   = ~ingress;

  // a static slot blocks both refresh and replacement
  assign lrn_we_o    = valid_i && learn_en_i && (src_age_i != AGE_STATIC);
  assign lrn_map_o   = ingress;
  assign lrn_proxy_o = (port_i == PORT_W'(CPU_PORT));

  assign hit_o   = learn_en_i && (dst_age_i != AGE_FREE) && (dst_ent_mac_i == dst_mac_i);
  assign map_o   = hit_o ? (dst_map_i & ~ingress) : flood;
  assign vid_o   = hit_o ? dst_vid_i : '0;
  assign proxy_o = hit_o && dst_proxy_i;
endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
  import mac_tbl_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int VID_W = 3,
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [MAC_W-1:0]  req_src_mac_i,
  input  logic [MAC_W-1:0]  req_dst_mac_i,
  input  logic [PORT_W-1:0] req_port_i,
  input  logic [VID_W-1:0]  req_vid_i,
  input  logic              learn_en_i,
  input  logic              hash_mode_i,
  input  logic              st_wr_i,
  input  logic [MAC_W-1:0]  st_mac_i,
  input  logic [NPORT-1:0]  st_port_map_i,
  input  logic [VID_W-1:0]  st_vid_i,
  input  logic              age_en_i,
  input  logic              age_tick_i,
  input  logic [DIV_W-1:0]  age_div_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [NPORT-1:0]  rsp_port_map_o,
  output logic [VID_W-1:0]  rsp_vid_o,
  output logic              rsp_proxy_o
);
  logic [IDX_W-1:0] src_idx, dst_idx, st_idx;

  mac_tbl_index #(.IDX_W(IDX_W)) u_src_idx (.mac_i(req_src_mac_i), .hash_i(hash_mode_i), .idx_o(src_idx));
  mac_tbl_index #(.IDX_W(IDX_W)) u_dst_idx (.mac_i(req_dst_mac_i), .hash_i(hash_mode_i), .idx_o(dst_idx));
  mac_tbl_index #(.IDX_W(IDX_W)) u_st_idx  (.mac_i(st_mac_i),      .hash_i(hash_mode_i), .idx_o(st_idx));

  // stage 1: registered request
  logic              s1_valid_q, s1_learn_q;
  mac_t              s1_src_q, s1_dst_q;
  logic [PORT_W-1:0] s1_port_q;
  logic [VID_W-1:0]  s1_vid_q;
  logic [IDX_W-1:0]  s1_src_idx_q, s1_dst_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q   <= 1'b0;
      s1_learn_q   <= 1'b0;
      s1_src_q     <= '0;
      s1_dst_q     <= '0;
      s1_port_q    <= '0;
      s1_vid_q     <= '0;
      s1_src_idx_q <= '0;
      s1_dst_idx_q <= '0;
    end else begin
      s1_valid_q <= req_valid_i;
      if (req_valid_i) begin
        s1_learn_q   <= learn_en_i;
        s1_src_q     <= req_src_mac_i;
        s1_dst_q     <= req_dst_mac_i;
        s1_port_q    <= req_port_i;
        s1_vid_q     <= req_vid_i;
        s1_src_idx_q <= src_idx;
        s1_dst_idx_q <= dst_idx;
      end
    end
  end

  logic             sweep;
  logic [IDX_W-1:0] sweep_idx;

  mac_tbl_age_ctl #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_age (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .age_en_i   (age_en_i),
    .tick_i     (age_tick_i),
    .div_i      (age_div_i),
    .sweep_o    (sweep),
    .sweep_idx_o(sweep_idx)
  );

  age_t             src_age, dst_age;
  mac_t             dst_ent_mac;
  pmap_t            dst_map, lrn_map, hit_map;
  logic [VID_W-1:0] dst_vid, hit_vid;
  logic             dst_proxy, lrn_we, lrn_proxy, hit, hit_proxy;

  mac_tbl_store #(.IDX_W(IDX_W), .VID_W(VID_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_idx_i  (s1_src_idx_q),
    .src_age_o  (src_age),
    .dst_idx_i  (s1_dst_idx_q),
    .dst_age_o  (dst_age),
    .dst_mac_o  (dst_ent_mac),
    .dst_map_o  (dst_map),
    .dst_vid_o  (dst_vid),
    .dst_proxy_o(dst_proxy),
    .lrn_we_i   (lrn_we),
    .lrn_idx_i  (s1_src_idx_q),
    .lrn_mac_i  (s1_src_q),
    .lrn_map_i  (lrn_map),
    .lrn_vid_i  (s1_vid_q),
    .lrn_proxy_i(lrn_proxy),
    .st_we_i    (st_wr_i),
    .st_idx_i   (st_idx),
    .st_mac_i   (st_mac_i),
    .st_map_i   (st_port_map_i),
    .st_vid_i   (st_vid_i),
    .sweep_i    (sweep),
    .sweep_idx_i(sweep_idx)
  );

  mac_tbl_decide #(.VID_W(VID_W)) u_decide (
    .valid_i      (s1_valid_q),
    .learn_en_i   (s1_learn_q),
    .port_i       (s1_port_q),
    .dst_mac_i    (s1_dst_q),
    .src_age_i    (src_age),
    .dst_age_i    (dst_age),
    .dst_ent_mac_i(dst_ent_mac),
    .dst_map_i    (dst_map),
    .dst_vid_i    (dst_vid),
    .dst_proxy_i  (dst_proxy),
    .lrn_we_o     (lrn_we),
    .lrn_map_o    (lrn_map),
    .lrn_proxy_o  (lrn_proxy),
    .hit_o        (hit),
    .map_o        (hit_map),
    .vid_o        (hit_vid),
    .proxy_o      (hit_proxy)
  );

  // stage 2: response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_hit_o      <= 1'b0;
      rsp_port_map_o <= '0;
      rsp_vid_o      <= '0;
      rsp_proxy_o    <= 1'b0;
    end else begin
      rsp_valid_o    <= s1_valid_q;
      rsp_hit_o      <= s1_valid_q && hit;
      rsp_port_map_o <= s1_valid_q ? hit_map : '0;
      rsp_vid_o      <= s1_valid_q ? hit_vid : '0;
      rsp_proxy_o    <= s1_valid_q && hit_proxy;
    end
  end
endmodule

// File: rtl/mac_learn_table_chk.sv
module mac_learn_table_chk
  import mac_tbl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [PORT_W-1:0] req_port_i,
  input logic              learn_en_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [NPORT-1:0]  rsp_port_map_o
);
  assert_rsp_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> ##2 rsp_valid_o);

  assert_rsp_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> ##2 !rsp_valid_o);

  assert_hit_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o && ($countones(rsp_port_map_o) <= 1));

  assert_miss_flood_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_port_map_o == ~port_bit($past(req_port_i, 2))));

  assert_no_echo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> ((rsp_port_map_o & port_bit($past(req_port_i, 2))) == '0));

  assert_hub_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !$past(learn_en_i, 2)) |-> !rsp_hit_o);
endmodule

bind mac_learn_table mac_learn_table_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_port_i    (req_port_i),
  .learn_en_i    (learn_en_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_port_map_o(rsp_port_map_o)
);

// File: tb/mac_learn_table_bench.sv
`timescale 1ns/1ps
module mac_learn_table_bench;
  localparam int DEPTH = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [47:0] req_src_mac_i = '0;
  logic [47:0] req_dst_mac_i = '0;
  logic [1:0]  req_port_i = '0;
  logic [2:0]  req_vid_i = '0;
  logic        learn_en_i = 1'b1;
  logic        hash_mode_i = 1'b0;
  logic        st_wr_i = 1'b0;
  logic [47:0] st_mac_i = '0;
  logic [2:0]  st_port_map_i = '0;
  logic [2:0]  st_vid_i = '0;
  logic        age_en_i = 1'b0;
  logic        age_tick_i = 1'b0;
  logic [15:0] age_div_i = 16'd1;
  logic        rsp_valid_o, rsp_hit_o, rsp_proxy_o;
  logic [2:0]  rsp_port_map_o, rsp_vid_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  mac_learn_table u_mac_learn_table (.*);

  localparam logic [47:0] MA = 48'h02AA_0000_0011;
  localparam logic [47:0] MB = 48'h02AA_0000_0022;
  localparam logic [47:0] MC = 48'h02AA_0000_0044;
  localparam logic [47:0] MD = 48'h02AA_0000_0055;
  localparam logic [47:0] ME = 48'h02AA_0000_0066;
  localparam logic [47:0] MF = 48'h02AA_0000_0077;
  localparam logic [47:0] MP = 48'h02AA_0000_03F0;
  localparam logic [47:0] MQ = 48'h02AA_0000_03E0;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_valid_i = 1'b0; learn_en_i = 1'b1; hash_mode_i = 1'b0;
    st_wr_i = 1'b0; age_en_i = 1'b0; age_tick_i = 1'b0; age_div_i = 16'd1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic lookup(input logic [47:0] s, input logic [47:0] d, input logic [1:0] p,
                        input logic [2:0] v);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_src_mac_i = s; req_dst_mac_i = d; req_port_i = p; req_vid_i = v;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic look_chk(input string rq, input logic [47:0] s, input logic [47:0] d,
                          input logic [1:0] p, input logic eh, input logic [2:0] em);
    lookup(s, d, p, 3'd0);
    chk(rq, {rsp_valid_o, rsp_hit_o, rsp_port_map_o}, {1'b1, eh, em});
  endtask

  task automatic tick();
    @(negedge clk_i); age_tick_i = 1'b1;
    @(negedge clk_i); age_tick_i = 1'b0;
    repeat (DEPTH + 8) @(negedge clk_i);
  endtask

  task automatic st_write(input logic [47:0] m, input logic [2:0] map, input logic [2:0] v);
    @(negedge clk_i);
    st_wr_i = 1'b1; st_mac_i = m; st_port_map_i = map; st_vid_i = v;
    @(negedge clk_i);
    st_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 reset outputs", {rsp_valid_o, rsp_hit_o, rsp_port_map_o, rsp_vid_o, rsp_proxy_o}, '0);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_src_mac_i = MA; req_dst_mac_i = MB; req_port_i = 2'd0; req_vid_i = 3'd0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R1 not yet valid", rsp_valid_o, 1'b0);
    @(negedge clk_i);
    chk("R1 valid at two edges", rsp_valid_o, 1'b1);
    @(negedge clk_i);
    chk("R1 single cycle", rsp_valid_o, 1'b0);
    look_chk("R2 learned before reset", MP, MA, 2'd2, 1'b1, 3'b001);
    do_reset();
    look_chk("R13 table empty after reset", MP, MA, 2'd2, 1'b0, 3'b011);
  endtask

  task automatic t_learn();
    do_reset();
    lookup(MA, MB, 2'd1, 3'd3);
    chk("R3 miss flood from LAN1", {rsp_hit_o, rsp_port_map_o}, {1'b0, 3'b101});
    lookup(MC, MA, 2'd0, 3'd0);
    chk("R2 hit map and vid", {rsp_hit_o, rsp_port_map_o, rsp_vid_o, rsp_proxy_o},
        {1'b1, 3'b010, 3'd3, 1'b0});
    lookup(MD, MA, 2'd2, 3'd6);
    chk("R2 hit from CPU", {rsp_hit_o, rsp_port_map_o}, {1'b1, 3'b010});
    lookup(ME, MD, 2'd0, 3'd0);
    chk("R2 CPU learned proxy", {rsp_hit_o, rsp_port_map_o, rsp_vid_o, rsp_proxy_o},
        {1'b1, 3'b100, 3'd6, 1'b1});
    look_chk("R4 hit on ingress port filtered", MF, MA, 2'd1, 1'b1, 3'b000);
    look_chk("R3 miss flood from CPU", MF, MQ, 2'd2, 1'b0, 3'b011);
    look_chk("R3 miss flood from LAN0", MP, MQ, 2'd0, 1'b0, 3'b110);
  endtask

  task automatic t_hub();
    do_reset();
    lookup(MA, MB, 2'd1, 3'd0);
    learn_en_i = 1'b0;
    look_chk("R5 hub floods known dst", MF, MA, 2'd2, 1'b0, 3'b011);
    learn_en_i = 1'b1;
    look_chk("R5 hub did not learn", MP, MF, 2'd0, 1'b0, 3'b110);
  endtask

  task automatic t_index();
    do_reset();
    lookup(48'h0000_0000_0123, MB, 2'd0, 3'd0);
    lookup(48'h0000_0000_0523, MB, 2'd1, 3'd0);
    look_chk("R7 direct collision replaces dynamic", MP, 48'h0000_0000_0123, 2'd2, 1'b0, 3'b011);
    look_chk("R6 direct slot holds newer", MP, 48'h0000_0000_0523, 2'd2, 1'b1, 3'b010);
    do_reset();
    hash_mode_i = 1'b1;
    lookup(48'h0000_0000_0123, MB, 2'd0, 3'd0);
    lookup(48'h0111_0000_0123, MB, 2'd1, 3'd0);
    look_chk("R6 hash separates low-bit twins a", MP, 48'h0000_0000_0123, 2'd2, 1'b1, 3'b001);
    look_chk("R6 hash separates low-bit twins b", MP, 48'h0111_0000_0123, 2'd2, 1'b1, 3'b010);
    lookup(48'h0001_0001_0123, MB, 2'd2, 3'd0);
    look_chk("R6 hash fold collision evicts", MP, 48'h0000_0000_0123, 2'd1, 1'b0, 3'b101);
    look_chk("R6 hash fold collision new entry", MP, 48'h0001_0001_0123, 2'd0, 1'b1, 3'b100);
  endtask

  task automatic t_static();
    do_reset();
    st_write(48'h0BEE_0000_0155, 3'b010, 3'd5);
    lookup(MP, 48'h0BEE_0000_0155, 2'd2, 3'd0);
    chk("R8 static lookup", {rsp_hit_o, rsp_port_map_o, rsp_vid_o}, {1'b1, 3'b010, 3'd5});
    lookup(48'h0BEE_0000_0155, MB, 2'd0, 3'd1);
    look_chk("R8 learn ignored on static", MP, 48'h0BEE_0000_0155, 2'd2, 1'b1, 3'b010);
    lookup(48'h0CCC_0000_0155, MB, 2'd0, 3'd0);
    look_chk("R7 colliding learn not stored", MP, 48'h0CCC_0000_0155, 2'd2, 1'b0, 3'b011);
    look_chk("R7 static kept after collision", MP, 48'h0BEE_0000_0155, 2'd2, 1'b1, 3'b010);
    age_en_i = 1'b1;
    for (int i = 0; i < 8; i++) tick();
    look_chk("R8 static survives aging", MP, 48'h0BEE_0000_0155, 2'd2, 1'b1, 3'b010);
  endtask

  task automatic t_age();
    do_reset();
    age_en_i = 1'b1;
    lookup(MA, MQ, 2'd0, 3'd0);
    lookup(MB, MQ, 2'd1, 3'd0);
    for (int i = 0; i < 5; i++) tick();
    look_chk("R9 A alive after five steps", MP, MA, 2'd2, 1'b1, 3'b001);
    look_chk("R9 B alive after five steps", MP, MB, 2'd2, 1'b1, 3'b010);
    lookup(MA, MQ, 2'd0, 3'd0);
    tick();
    look_chk("R9 B aged out at sixth step", MP, MB, 2'd2, 1'b0, 3'b011);
    look_chk("R10 refreshed A alive", MP, MA, 2'd2, 1'b1, 3'b001);
    for (int i = 0; i < 4; i++) tick();
    look_chk("R10 A alive at age six", MP, MA, 2'd2, 1'b1, 3'b001);
    tick();
    look_chk("R10 A aged out", MP, MA, 2'd2, 1'b0, 3'b011);
  endtask

  task automatic t_age_ctl();
    do_reset();
    lookup(MA, MQ, 2'd0, 3'd0);
    for (int i = 0; i < 7; i++) tick();
    look_chk("R11 disabled aging ignores ticks", MP, MA, 2'd2, 1'b1, 3'b001);
    age_en_i = 1'b1;
    age_div_i = 16'd2;
    for (int i = 0; i < 11; i++) tick();
    look_chk("R12 five steps in eleven ticks", MP, MA, 2'd2, 1'b1, 3'b001);
    tick();
    look_chk("R12 sixth step at twelfth tick", MP, MA, 2'd2, 1'b0, 3'b011);
    do_reset();
    lookup(MB, MQ, 2'd1, 3'd0);
    age_en_i = 1'b1;
    age_div_i = 16'd0;
    for (int i = 0; i < 5; i++) tick();
    look_chk("R12 divider zero five ticks", MP, MB, 2'd2, 1'b1, 3'b010);
    tick();
    look_chk("R12 divider zero acts as one", MP, MB, 2'd2, 1'b0, 3'b011);
  endtask

  initial begin
    t_reset();
    t_learn();
    t_hub();
    t_index();
    t_static();
    t_age();
    t_age_ctl();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule